// File: doc/BRIEF.md
# Copy-on-Write Block Remap Write Sequencer

This block carries out one host write once the address has already been translated to a set-based physical location. The translator supplies the logical set, the physical set the data lives in now, the physical set it should live in afterwards, the status codes of the slots in both sets, the block offset inside the logical set and the page inside the block. Each slot's status is a small code: a value below SL names the block offset whose data the slot holds, SL marks a free slot and SL+1 marks a defective slot. New data never overwrites a page in place. The sequencer takes a fresh free slot, rebuilds the whole block there page by page with the host page substituted, and frees the old block by erasing it only when the data stayed in the same physical set.

When the flash work is done, the set status is turned back into a compact row index of a static table that enumerates every possible combination of slot codes. That index is written into the physical set table, and the logical set table is rewritten when the data changed sets. A second command kind marks one slot of a set as defective and updates the physical set table entry in the same way, without touching the flash.

States: IDLE (waits for a command), ALLOC (picks a free slot or reports a full set), STEP (chooses between reading a page and programming it), RD_ISSUE and RD_WAIT (read one old page), PG_ISSUE and PG_WAIT (program one page), ER_ISSUE and ER_WAIT (erase the old block), SEARCH (walks the combination table one row per cycle), COMMIT (writes the tables and signals completion), FULL (signals that no slot is free). Transitions: IDLE to ALLOC on a write, IDLE to SEARCH on a defect mark, ALLOC to FULL or STEP, STEP to PG_ISSUE on the target page and to RD_ISSUE on any other page, RD_WAIT to PG_ISSUE on done, PG_WAIT to STEP for the next page, PG_WAIT to ER_ISSUE after the last page when the set did not change and an old block existed, PG_WAIT to SEARCH otherwise, ER_WAIT to SEARCH on done, SEARCH to COMMIT on a match, COMMIT and FULL to IDLE.

Top module: `remap_wr_seq`

## Requirements
- R1: When no slot of the current set holds the requested offset, the lowest-indexed slot of the destination set with code SL is taken, only the target page is programmed into that block (block address = set * SP + slot), and no page is read.
- R2: When a slot holds the offset, a different free block is taken and every page is programmed into it in order from page 0 to the last, each holding the data read from the same page of the old block, except the target page, which holds the host data.
- R3: When the destination set differs from the current set, pages are read from the block in the current set, the new block lies in the destination set, and the logical set table entry of the command's logical set is written with the destination set number.
- R4: When the set is unchanged and an old block existed, the old block is erased after the last page is programmed and its slot code becomes SL (free).
- R5: At completion the physical set table entry of the destination set is written with the row index whose base-(SL+2) digit i, least significant first, equals the final code of slot i.
- R6: When the set changed, the old block is not erased and its data stays intact.
- R7: When the destination set has no slot with code SL, a one-cycle full error is raised, no flash command is issued and no table is written.
- R8: A defect-mark command sets the named slot's code to SL+1 and writes the matching row index into the physical set table entry of that set, with no flash command and no logical set table write.
- R9: Each flash command is a one-cycle pulse, at most one kind at a time, and none is issued while an earlier one is waiting for its done pulse.
- R10: The command is accepted only while ready is high; ready is high only when idle, done is a one-cycle pulse given together with the physical set table write, and ready is high again in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command taken |
| cmd_defect | input | 1 | 1 = mark slot defective, 0 = write |
| cmd_lset | input | LSW | Logical set number |
| cmd_pset_old | input | PSW | Physical set holding the data now |
| cmd_pset_new | input | PSW | Physical set to hold the data afterwards |
| cmd_old_stat | input | SP*CW | Slot codes of the current set, slot i at bits i*CW |
| cmd_new_stat | input | SP*CW | Slot codes of the destination set |
| cmd_offset | input | OW | Block offset inside the logical set |
| cmd_page | input | PGW | Target page inside the block |
| cmd_slot | input | SSW | Slot to mark defective |
| host_data | input | DW | Data for the target page, taken with the command |
| fl_rd | output | 1 | Page read pulse |
| fl_prog | output | 1 | Page program pulse |
| fl_erase | output | 1 | Block erase pulse |
| fl_blk | output | BW | Physical block address |
| fl_page | output | PGW | Page address |
| fl_wdata | output | DW | Program data |
| fl_rdata | input | DW | Read data, valid with fl_done |
| fl_done | input | 1 | Completion pulse of the pending flash command |
| pst_we | output | 1 | Physical set table write |
| pst_addr | output | PSW | Physical set table entry |
| pst_row | output | RW | Combination row index written |
| lst_we | output | 1 | Logical set table write |
| lst_addr | output | LSW | Logical set table entry |
| lst_pset | output | PSW | Physical set number written |
| done | output | 1 | Command finished |
| err_full | output | 1 | No free slot in the destination set |

## Verification
The block's latency depends on the flash model's done timing and on how far the combination search must walk, so no result has a fixed cycle count after the command; the bench instead waits, sampling on falling edges, for the done or full-error pulse and bounds that wait. Table writes are logged on the rising edge where they are high, which is the same edge that ends the COMMIT state, so the logged values, the flash contents and the return of ready are all read at the falling edge right after it. Flash operations are counted and the programmed page order recorded as they are issued, so reads, programs and erases belonging to one command are compared as differences before and after it.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ALLOC,
        S_STEP,
        S_RD_ISSUE,
        S_RD_WAIT,
        S_PG_ISSUE,
        S_PG_WAIT,
        S_ER_ISSUE,
        S_ER_WAIT,
        S_SEARCH,
        S_COMMIT,
        S_FULL
    } seq_state_t;

endpackage

// File: rtl/slot_scan.sv
// Finds the lowest-indexed slot whose status code equals the key.
module slot_scan #(
    parameter int SP  = 4,
    parameter int CW  = 2,
    localparam int SSW = (SP > 1) ? $clog2(SP) : 1
) (
    input  logic [SP*CW-1:0] stat,
    input  logic [CW-1:0]    key,
    output logic             found,
    output logic [SSW-1:0]   idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SP - 1; i >= 0; i--) begin
            if (stat[i*CW +: CW] == key) begin
                found = 1'b1;
                idx   = SSW'(i);
            end
        end
    end
endmodule

// File: rtl/uit_rom.sv
// Static combination table: row r holds, in slot i, base-BASE digit i of r.
module uit_rom #(
    parameter int SP   = 4,
    parameter int BASE = 4,
    parameter int CW   = 2,
    parameter int RW   = 8
) (
    input  logic [RW-1:0]    idx,
    output logic [SP*CW-1:0] row
);
    for (genvar i = 0; i < SP; i++) begin : g_digit
        localparam int unsigned DIV = BASE ** i;
        logic [RW-1:0] quot;
        assign quot = idx / RW'(DIV);
        assign row[i*CW +: CW] = CW'(quot % RW'(BASE));
    end
endmodule

// File: rtl/remap_wr_seq.sv
module remap_wr_seq
    import remap_pkg::*;
#(
    parameter int SL     = 2,
    parameter int SP     = 4,
    parameter int PAGES  = 4,
    parameter int DW     = 8,
    parameter int NLSET  = 16,
    parameter int NPSET  = 16,
    localparam int BASE  = SL + 2,
    localparam int CW    = $clog2(BASE),
    localparam int SW    = SP * CW,
    localparam int ROWS  = BASE ** SP,
    localparam int RW    = $clog2(ROWS),
    localparam int OW    = (SL > 1) ? $clog2(SL) : 1,
    localparam int SSW   = (SP > 1) ? $clog2(SP) : 1,
    localparam int PGW   = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int LSW   = (NLSET > 1) ? $clog2(NLSET) : 1,
    localparam int PSW   = (NPSET > 1) ? $clog2(NPSET) : 1,
    localparam int BW    = $clog2(NPSET * SP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    output logic           cmd_ready,
    input  logic           cmd_defect,
    input  logic [LSW-1:0] cmd_lset,
    input  logic [PSW-1:0] cmd_pset_old,
    input  logic [PSW-1:0] cmd_pset_new,
    input  logic [SW-1:0]  cmd_old_stat,
    input  logic [SW-1:0]  cmd_new_stat,
    input  logic [OW-1:0]  cmd_offset,
    input  logic [PGW-1:0] cmd_page,
    input  logic [SSW-1:0] cmd_slot,
    input  logic [DW-1:0]  host_data,
    output logic           fl_rd,
    output logic           fl_prog,
    output logic           fl_erase,
    output logic [BW-1:0]  fl_blk,
    output logic [PGW-1:0] fl_page,
    output logic [DW-1:0]  fl_wdata,
    input  logic [DW-1:0]  fl_rdata,
    input  logic           fl_done,
    output logic           pst_we,
    output logic [PSW-1:0] pst_addr,
    output logic [RW-1:0]  pst_row,
    output logic           lst_we,
    output logic [LSW-1:0] lst_addr,
    output logic [PSW-1:0] lst_pset,
    output logic           done,
    output logic           err_full
);
    localparam logic [CW-1:0]  CODE_FREE = CW'(SL);
    localparam logic [CW-1:0]  CODE_BAD  = CW'(SL + 1);
    localparam logic [PGW-1:0] LAST_PG   = PGW'(PAGES - 1);

    seq_state_t state_q, state_d;

    logic           defect_q;
    logic [LSW-1:0] lset_q;
    logic [PSW-1:0] pold_q, pnew_q;
    logic [SW-1:0]  oldstat_q, newstat_q, stat_q;
    logic [OW-1:0]  offset_q;
    logic [PGW-1:0] page_q, pg_q;
    logic [DW-1:0]  host_q, buf_q;
    logic [RW-1:0]  srch_q;

    logic           changed;
    logic [PSW-1:0] tgt_set;
    logic [SW-1:0]  tgt_stat;
    logic           hit, free_ok;
    logic [SSW-1:0] oslot, nslot;
    logic [SW-1:0]  rom_row;
    logic           match;

    function automatic logic [SW-1:0] put_code(input logic [SW-1:0] v,
                                               input logic [SSW-1:0] s,
                                               input logic [CW-1:0] c);
        logic [SW-1:0] r;
        r = v;
        for (int i = 0; i < SP; i++) begin
            if (SSW'(i) == s) r[i*CW +: CW] = c;
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] blk_of(input logic [PSW-1:0] set,
                                             input logic [SSW-1:0] slot);
        return BW'(set) * BW'(SP) + BW'(slot);
    endfunction

    assign changed  = (pnew_q != pold_q);
    assign tgt_set  = defect_q ? pold_q : pnew_q;
    assign tgt_stat = changed ? newstat_q : oldstat_q;

    slot_scan #(.SP(SP), .CW(CW)) i_hit_scan (
        .stat  (oldstat_q),
        .key   (CW'(offset_q)),
        .found (hit),
        .idx   (oslot)
    );

    slot_scan #(.SP(SP), .CW(CW)) i_free_scan (
        .stat  (tgt_stat),
        .key   (CODE_FREE),
        .found (free_ok),
        .idx   (nslot)
    );

    uit_rom #(.SP(SP), .BASE(BASE), .CW(CW), .RW(RW)) i_uit_rom (
        .idx (srch_q),
        .row (rom_row)
    );

    assign match = (rom_row == stat_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (cmd_valid) state_d = cmd_defect ? S_SEARCH : S_ALLOC;
            S_ALLOC:    state_d = free_ok ? S_STEP : S_FULL;
            S_STEP:     state_d = (pg_q == page_q) ? S_PG_ISSUE : S_RD_ISSUE;
            S_RD_ISSUE: state_d = S_RD_WAIT;
            S_RD_WAIT:  if (fl_done) state_d = S_PG_ISSUE;
            S_PG_ISSUE: state_d = S_PG_WAIT;
            S_PG_WAIT: begin
                if (fl_done) begin
                    if (hit && pg_q != LAST_PG) state_d = S_STEP;
                    else if (hit && !changed)   state_d = S_ER_ISSUE;
                    else                        state_d = S_SEARCH;
                end
            end
            S_ER_ISSUE: state_d = S_ER_WAIT;
            S_ER_WAIT:  if (fl_done) state_d = S_SEARCH;
            S_SEARCH:   if (match) state_d = S_COMMIT;
            S_COMMIT:   state_d = S_IDLE;
            S_FULL:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            defect_q  <= 1'b0;
            lset_q    <= '0;
            pold_q    <= '0;
            pnew_q    <= '0;
            oldstat_q <= '0;
            newstat_q <= '0;
            stat_q    <= '0;
            offset_q  <= '0;
            page_q    <= '0;
            pg_q      <= '0;
            host_q    <= '0;
            buf_q     <= '0;
            srch_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        defect_q  <= cmd_defect;
                        lset_q    <= cmd_lset;
                        pold_q    <= cmd_pset_old;
                        pnew_q    <= cmd_defect ? cmd_pset_old : cmd_pset_new;
                        oldstat_q <= cmd_old_stat;
                        newstat_q <= cmd_new_stat;
                        offset_q  <= cmd_offset;
                        page_q    <= cmd_page;
                        host_q    <= host_data;
                        srch_q    <= '0;
                        stat_q    <= put_code(cmd_old_stat, cmd_slot, CODE_BAD);
                    end
                end
                S_ALLOC: begin
                    if (free_ok) begin
                        pg_q   <= hit ? '0 : page_q;
                        stat_q <= put_code(tgt_stat, nslot, CW'(offset_q));
                    end
                end
                S_RD_WAIT: if (fl_done) buf_q <= fl_rdata;
                S_PG_WAIT: if (fl_done && hit && pg_q != LAST_PG) pg_q <= pg_q + 1'b1;
                S_ER_WAIT: if (fl_done) stat_q <= put_code(stat_q, oslot, CODE_FREE);
                S_SEARCH:  if (!match) srch_q <= srch_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        fl_rd     = (state_q == S_RD_ISSUE);
        fl_prog   = (state_q == S_PG_ISSUE);
        fl_erase  = (state_q == S_ER_ISSUE);
        fl_blk    = (state_q == S_PG_ISSUE || state_q == S_PG_WAIT)
                    ? blk_of(tgt_set, nslot) : blk_of(pold_q, oslot);
        fl_page   = pg_q;
        fl_wdata  = (pg_q == page_q) ? host_q : buf_q;
        pst_we    = (state_q == S_COMMIT);
        pst_addr  = tgt_set;
        pst_row   = srch_q;
        lst_we    = (state_q == S_COMMIT) && !defect_q && changed;
        lst_addr  = lset_q;
        lst_pset  = pnew_q;
        done      = (state_q == S_COMMIT);
        err_full  = (state_q == S_FULL);
    end

endmodule

// File: rtl/remap_wr_seq_chk.sv
module remap_wr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic cmd_defect,
    input logic fl_rd,
    input logic fl_prog,
    input logic fl_erase,
    input logic fl_done,
    input logic pst_we,
    input logic lst_we,
    input logic done,
    input logic err_full
);
    logic any_req;
    logic pending_q;
    logic defect_run_q;

    assign any_req = fl_rd | fl_prog | fl_erase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q    <= 1'b0;
            defect_run_q <= 1'b0;
        end else begin
            if (any_req)      pending_q <= 1'b1;
            else if (fl_done) pending_q <= 1'b0;
            if (cmd_valid && cmd_ready && cmd_defect) defect_run_q <= 1'b1;
            else if (done)                             defect_run_q <= 1'b0;
        end
    end

    assert_one_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_rd, fl_prog, fl_erase}));

    assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !any_req);

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> !any_req);

    assert_full_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_full |-> (!pst_we && !lst_we && !any_req));

    assert_full_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_full |=> !err_full);

    assert_lst_with_pst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lst_we |-> pst_we);

    assert_defect_no_flash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        defect_run_q |-> (!any_req && !lst_we));

    assert_done_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pst_we && !cmd_ready));

    assert_ready_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);

endmodule

bind remap_wr_seq remap_wr_seq_chk i_remap_wr_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_defect (cmd_defect),
    .fl_rd      (fl_rd),
    .fl_prog    (fl_prog),
    .fl_erase   (fl_erase),
    .fl_done    (fl_done),
    .pst_we     (pst_we),
    .lst_we     (lst_we),
    .done       (done),
    .err_full   (err_full)
);

// File: tb/test_remap_wr_seq.sv
`timescale 1ns/1ps
module test_remap_wr_seq;
    localparam int SW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_defect = 1'b0;
    logic [3:0] cmd_lset = '0;
    logic [3:0] cmd_pset_old = '0;
    logic [3:0] cmd_pset_new = '0;
    logic [SW-1:0] cmd_old_stat = '0;
    logic [SW-1:0] cmd_new_stat = '0;
    logic [0:0] cmd_offset = '0;
    logic [1:0] cmd_page = '0;
    logic [1:0] cmd_slot = '0;
    logic [7:0] host_data = '0;
    logic       fl_rd, fl_prog, fl_erase;
    logic [5:0] fl_blk;
    logic [1:0] fl_page;
    logic [7:0] fl_wdata;
    logic [7:0] fl_rdata;
    logic       fl_done;
    logic       pst_we;
    logic [3:0] pst_addr;
    logic [7:0] pst_row;
    logic       lst_we;
    logic [3:0] lst_addr;
    logic [3:0] lst_pset;
    logic       done;
    logic       err_full;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    remap_wr_seq i_remap_wr_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_defect(cmd_defect),
        .cmd_lset(cmd_lset), .cmd_pset_old(cmd_pset_old), .cmd_pset_new(cmd_pset_new),
        .cmd_old_stat(cmd_old_stat), .cmd_new_stat(cmd_new_stat),
        .cmd_offset(cmd_offset), .cmd_page(cmd_page), .cmd_slot(cmd_slot),
        .host_data(host_data),
        .fl_rd(fl_rd), .fl_prog(fl_prog), .fl_erase(fl_erase),
        .fl_blk(fl_blk), .fl_page(fl_page), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .fl_done(fl_done),
        .pst_we(pst_we), .pst_addr(pst_addr), .pst_row(pst_row),
        .lst_we(lst_we), .lst_addr(lst_addr), .lst_pset(lst_pset),
        .done(done), .err_full(err_full)
    );

    // Flash model and event logger
    logic [7:0] mem [0:63][0:3];
    logic       pend;
    int         lat;
    int         op_kind;
    logic [5:0] op_blk;
    logic [1:0] op_page;
    logic [7:0] op_data;
    logic       pre_we = 1'b0;
    logic [5:0] pre_blk = '0;
    logic [1:0] pre_page = '0;
    logic [7:0] pre_data = '0;
    int n_rd, n_prog, n_erase, n_done, n_err, n_pst, n_lst;
    logic [3:0] pst_a_log, lst_a_log, lst_d_log;
    logic [7:0] pst_r_log;
    logic [7:0] prog_seq;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 64; b++)
                for (int p = 0; p < 4; p++) mem[b][p] <= 8'hFF;
            pend <= 1'b0; lat <= 0; op_kind <= 0; fl_done <= 1'b0; fl_rdata <= '0;
            op_blk <= '0; op_page <= '0; op_data <= '0;
            n_rd <= 0; n_prog <= 0; n_erase <= 0; n_done <= 0; n_err <= 0;
            n_pst <= 0; n_lst <= 0; pst_a_log <= '0; pst_r_log <= '0;
            lst_a_log <= '0; lst_d_log <= '0; prog_seq <= '0;
        end else begin
            fl_done <= 1'b0;
            if (pre_we) mem[pre_blk][pre_page] <= pre_data;
            if (pend) begin
                if (lat == 0) begin
                    pend <= 1'b0;
                    fl_done <= 1'b1;
                    if (op_kind == 1) fl_rdata <= mem[op_blk][op_page];
                    else if (op_kind == 2) mem[op_blk][op_page] <= op_data;
                    else for (int p = 0; p < 4; p++) mem[op_blk][p] <= 8'hFF;
                end else lat <= lat - 1;
            end else if (fl_rd | fl_prog | fl_erase) begin
                pend <= 1'b1; lat <= 1;
                op_kind <= fl_rd ? 1 : (fl_prog ? 2 : 3);
                op_blk <= fl_blk; op_page <= fl_page; op_data <= fl_wdata;
                if (fl_rd) n_rd <= n_rd + 1;
                if (fl_prog) begin
                    n_prog <= n_prog + 1;
                    prog_seq <= {prog_seq[5:0], fl_page};
                end
                if (fl_erase) n_erase <= n_erase + 1;
            end
            if (done) n_done <= n_done + 1;
            if (err_full) n_err <= n_err + 1;
            if (pst_we) begin n_pst <= n_pst + 1; pst_a_log <= pst_addr; pst_r_log <= pst_row; end
            if (lst_we) begin n_lst <= n_lst + 1; lst_a_log <= lst_addr; lst_d_log <= lst_pset; end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pk(input int c0, input int c1, input int c2, input int c3);
        return 8'(c0 | (c1 << 2) | (c2 << 4) | (c3 << 6));
    endfunction

    // Row index per R5: base-4 digits, slot 0 least significant
    function automatic int row_of(input int c0, input int c1, input int c2, input int c3);
        return c0 + 4 * c1 + 16 * c2 + 64 * c3;
    endfunction

    task automatic preload(input int blk, input int base);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_blk = 6'(blk); pre_page = 2'(p); pre_data = 8'(base + p);
        end
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic send(input bit defect, input int lset, input int pold, input int pnew,
                        input logic [7:0] ostat, input logic [7:0] nstat,
                        input int off, input int page, input int slot, input int data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_defect = defect; cmd_lset = 4'(lset);
        cmd_pset_old = 4'(pold); cmd_pset_new = 4'(pnew);
        cmd_old_stat = ostat; cmd_new_stat = nstat;
        cmd_offset = 1'(off); cmd_page = 2'(page); cmd_slot = 2'(slot);
        host_data = 8'(data);
        @(negedge clk);
        cmd_valid = 1'b0; host_data = 8'h00;
    endtask

    task automatic wait_end(input int d0, input int e0, input string req);
        int t = 0;
        while (n_done == d0 && n_err == e0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 2000, req, "command finished", t, 0);
    endtask

    task automatic t_reset;
        chk(cmd_ready == 1'b1, "R10", "ready after reset", int'(cmd_ready), 1);
        chk({fl_rd, fl_prog, fl_erase} == 3'b000, "R9", "no flash command after reset",
            int'({fl_rd, fl_prog, fl_erase}), 0);
        chk({pst_we, lst_we, done, err_full} == 4'b0, "R10", "quiet outputs after reset",
            int'({pst_we, lst_we, done, err_full}), 0);
    endtask

    task automatic t_first_write;
        int d0 = n_done, e0 = n_err, r0 = n_rd, p0 = n_prog, x0 = n_erase, l0 = n_lst;
        send(1'b0, 1, 3, 3, pk(2,2,2,2), pk(2,2,2,2), 1, 2, 0, 8'h3C);
        wait_end(d0, e0, "R1");
        chk(mem[12][2] == 8'h3C, "R1", "target page in slot 0 block", int'(mem[12][2]), 8'h3C);
        chk(mem[12][0] == 8'hFF, "R1", "other page untouched", int'(mem[12][0]), 8'hFF);
        chk(n_prog - p0 == 1, "R1", "program count", n_prog - p0, 1);
        chk(n_rd - r0 == 0, "R1", "read count", n_rd - r0, 0);
        chk(n_erase - x0 == 0, "R4", "no erase without old block", n_erase - x0, 0);
        chk(pst_a_log == 4'd3, "R5", "pst entry", int'(pst_a_log), 3);
        chk(int'(pst_r_log) == row_of(1,2,2,2), "R5", "pst row", int'(pst_r_log), row_of(1,2,2,2));
        chk(n_lst == l0, "R3", "no lst write when set kept", n_lst - l0, 0);
        chk(cmd_ready == 1'b1, "R10", "ready after done", int'(cmd_ready), 1);
    endtask

    task automatic t_update_same_set;
        int d0, e0, r0, p0, x0, l0;
        preload(12, 8'hC0);
        d0 = n_done; e0 = n_err; r0 = n_rd; p0 = n_prog; x0 = n_erase; l0 = n_lst;
        send(1'b0, 1, 3, 3, pk(1,0,2,2), pk(0,0,0,0), 1, 1, 0, 8'h5A);
        wait_end(d0, e0, "R2");
        chk(mem[14][0] == 8'hC0 && mem[14][2] == 8'hC2 && mem[14][3] == 8'hC3, "R2",
            "copied pages", int'(mem[14][3]), 8'hC3);
        chk(mem[14][1] == 8'h5A, "R2", "host page substituted", int'(mem[14][1]), 8'h5A);
        chk(prog_seq == 8'h1B, "R2", "program order 0..3", int'(prog_seq), 8'h1B);
        chk(n_rd - r0 == 3, "R2", "read count", n_rd - r0, 3);
        chk(n_erase - x0 == 1, "R4", "old block erased", n_erase - x0, 1);
        chk(mem[12][0] == 8'hFF && mem[12][3] == 8'hFF, "R4", "old block blank",
            int'(mem[12][0]), 8'hFF);
        chk(int'(pst_r_log) == row_of(2,0,1,2), "R4", "freed slot in row",
            int'(pst_r_log), row_of(2,0,1,2));
        chk(n_lst == l0, "R3", "no lst write", n_lst - l0, 0);
    endtask

    task automatic t_set_change;
        int d0, e0, x0, l0;
        preload(12, 8'hD0);
        d0 = n_done; e0 = n_err; x0 = n_erase; l0 = n_lst;
        send(1'b0, 9, 3, 5, pk(0,2,2,2), pk(3,1,2,2), 0, 3, 0, 8'h77);
        wait_end(d0, e0, "R3");
        chk(mem[22][0] == 8'hD0 && mem[22][1] == 8'hD1 && mem[22][2] == 8'hD2, "R3",
            "pages from original set", int'(mem[22][0]), 8'hD0);
        chk(mem[22][3] == 8'h77, "R3", "host page in new set", int'(mem[22][3]), 8'h77);
        chk(n_erase == x0, "R6", "no erase on set change", n_erase - x0, 0);
        chk(mem[12][0] == 8'hD0 && mem[12][3] == 8'hD3, "R6", "old block intact",
            int'(mem[12][3]), 8'hD3);
        chk(pst_a_log == 4'd5, "R5", "pst entry of new set", int'(pst_a_log), 5);
        chk(int'(pst_r_log) == row_of(3,1,0,2), "R5", "pst row new set",
            int'(pst_r_log), row_of(3,1,0,2));
        chk(n_lst - l0 == 1 && lst_a_log == 4'd9 && lst_d_log == 4'd5, "R3", "lst write",
            int'(lst_d_log), 5);
    endtask

    task automatic t_lowest_free;
        int d0 = n_done, e0 = n_err;
        send(1'b0, 2, 6, 6, pk(3,2,0,2), pk(0,0,0,0), 1, 0, 0, 8'h11);
        wait_end(d0, e0, "R1");
        chk(mem[25][0] == 8'h11, "R1", "lowest free slot 1 used", int'(mem[25][0]), 8'h11);
        chk(mem[27][0] == 8'hFF, "R1", "slot 3 unused", int'(mem[27][0]), 8'hFF);
        chk(int'(pst_r_log) == row_of(3,1,0,2), "R5", "pst row", int'(pst_r_log), row_of(3,1,0,2));
    endtask

    task automatic t_full;
        int d0 = n_done, e0 = n_err, r0 = n_rd, p0 = n_prog, x0 = n_erase;
        int s0 = n_pst, l0 = n_lst;
        send(1'b0, 4, 2, 2, pk(0,1,3,3), pk(0,0,0,0), 0, 0, 0, 8'h99);
        wait_end(d0, e0, "R7");
        chk(n_err - e0 == 1, "R7", "full error pulse", n_err - e0, 1);
        chk(n_done == d0, "R7", "no done", n_done - d0, 0);
        chk(n_pst == s0 && n_lst == l0, "R7", "no table write", n_pst - s0, 0);
        chk(n_rd == r0 && n_prog == p0 && n_erase == x0, "R7", "no flash command",
            n_prog - p0, 0);
        chk(cmd_ready == 1'b1, "R10", "ready after error", int'(cmd_ready), 1);
    endtask

    task automatic t_defect;
        int d0 = n_done, e0 = n_err, p0 = n_prog, r0 = n_rd, l0 = n_lst;
        send(1'b1, 0, 7, 0, pk(2,2,2,2), pk(0,0,0,0), 0, 0, 3, 0);
        wait_end(d0, e0, "R8");
        chk(pst_a_log == 4'd7, "R8", "pst entry", int'(pst_a_log), 7);
        chk(int'(pst_r_log) == row_of(2,2,2,3), "R8", "defect code in row",
            int'(pst_r_log), row_of(2,2,2,3));
        chk(n_prog == p0 && n_rd == r0 && n_lst == l0, "R8", "no flash or lst activity",
            n_prog - p0, 0);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_write();
        t_update_same_set();
        t_set_change();
        t_lowest_free();
        t_full();
        t_defect();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule